// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block keeps a free-running count of elapsed microseconds while clocked from a reference of arbitrary frequency. A rational prescaler sits between the reference clock and the count. On each reference cycle it adds a programmed numerator to a small rate accumulator. Whenever the accumulator reaches the programmed denominator, one microsecond tick is issued. Reference clocks that are not a whole multiple of 1 MHz therefore still produce an exact 1 MHz average. For example, 19.2 MHz uses the ratio 5/96.

Software reaches the block through a single-cycle register port inside a 0x60-byte window. The port holds a read-only count register and a read/write scale register. Reads are captured on the clock edge of the strobe and presented on the data output from the next cycle. Every other offset reads as zero.

Top module: `usct_timebase`

## Requirements
- R1: After reset the scale register reads 0x0000, which means a ratio of 1/1. The count and the accumulator start from zero, and the read data output is zero.
- R2: The scale register at byte offset 0x14 holds the denominator minus one in bits [7:0] and the numerator minus one in bits [15:8]. Bits above 15 are not stored and read as zero.
- R3: While the numerator n is below the denominator d, the count advanced by floor(n*k/d) exactly k cycles after a scale write. Examples are 0x000B (1/12), 0x000C (1/13), 0x0019 (1/26) and 0x045F (5/96).
- R4: While n is at least d, the count advances by exactly one on every cycle and never by more.
- R5: A write to the scale register clears the accumulator and issues no tick in its own cycle. It leaves the count unchanged.
- R6: A write to the count offset 0x10, or to any offset other than 0x14, changes neither the count nor the scale register.
- R7: A read of any byte address other than exactly 0x10 or 0x14 returns zero. This covers unaligned addresses and addresses beyond 0x5F.
- R8: A read returns the value the register held in the cycle of the read strobe. The value appears on the data output after that clock edge and stays there until the next read.
- R9: The count wraps from its all-ones value to zero on a tick, with no other effect.
- R10: The tick output is high in exactly the cycles whose closing edge increments the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | ADDR_W (7) | Byte address within the register window |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| usec_tick | output | 1 | High in cycles that advance the count |

## Verification
The embedded assertions watch, on every cycle, the single-step and hold behaviour of the count and its wrap. They also check that the accumulator stays below the denominator, that the rate is one per cycle at or above unity, that the count freezes across a scale write, and that read data holds between reads.

The exact tick cadence of each ratio can only be shown by the bench's scenarios, which compare reads against a closed-form count. The same holds for the field layout of the scale register, the zero reads across the window, and the behaviour of ignored writes. A second, narrow-count instance on the same bus lets the bench observe a wrap within the run.

// File: rtl/usct_pkg.sv
package usct_pkg;
   typedef enum logic [1:0] {
      SLOT_NONE  = 2'd0,
      SLOT_COUNT = 2'd1,
      SLOT_SCALE = 2'd2
   } slot_e;
endpackage

// File: rtl/usct_decode.sv
module usct_decode
   import usct_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int CNT_OFS   = 16,
   parameter int CFG_OFS   = 20,
   parameter int WIN_BYTES = 96
) (
   input  logic [ADDR_W-1:0] addr,
   output slot_e             slot
);
   if (WIN_BYTES > (1 << ADDR_W)) begin : g_bad_win
      $error("usct_decode: window does not fit the address width");
   end
   if ((CNT_OFS % 4 != 0) || (CFG_OFS % 4 != 0)) begin : g_bad_align
      $error("usct_decode: register offsets must be word aligned");
   end
   if ((CNT_OFS >= WIN_BYTES) || (CFG_OFS >= WIN_BYTES) || (CNT_OFS == CFG_OFS)) begin : g_bad_ofs
      $error("usct_decode: offsets must be distinct and inside the window");
   end

   always_comb begin
      if (addr == ADDR_W'(CNT_OFS))      slot = SLOT_COUNT;
      else if (addr == ADDR_W'(CFG_OFS)) slot = SLOT_SCALE;
      else                               slot = SLOT_NONE;
   end
endmodule

// File: rtl/usct_rate_accum.sv
module usct_rate_accum #(
   parameter int FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic [FIELD_W-1:0] num_m1,
   input  logic [FIELD_W-1:0] den_m1,
   output logic               tick
);
   localparam int ACC_W = FIELD_W + 1;
   localparam int SUM_W = FIELD_W + 2;

   if (FIELD_W < 1) begin : g_bad_field
      $error("usct_rate_accum: FIELD_W must be at least 1");
   end

   logic [ACC_W-1:0] num, den, acc_q, acc_d;
   logic [SUM_W-1:0] sum;
   logic             saturate;

   assign num      = {1'b0, num_m1} + ACC_W'(1);
   assign den      = {1'b0, den_m1} + ACC_W'(1);
   assign sum      = SUM_W'(acc_q) + SUM_W'(num);
   assign saturate = (num >= den);

   always_comb begin
      tick  = 1'b0;
      acc_d = acc_q;
      if (clear) begin
         acc_d = '0;
      end else if (saturate) begin
         tick  = 1'b1;
         acc_d = '0;
      end else if (sum >= SUM_W'(den)) begin
         tick  = 1'b1;
         acc_d = ACC_W'(sum - SUM_W'(den));
      end else begin
         acc_d = ACC_W'(sum);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   // R3: the remainder never reaches the denominator it is measured against
   a_r3_acc_below_den: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < den);
   // R5: a clear leaves the accumulator at zero on the following cycle
   a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (acc_q == '0));
endmodule

// File: rtl/usct_counter.sv
module usct_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("usct_counter: CNT_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (tick) count <= count + CNT_W'(1);
   end

   // R10: a tick moves the count by one
   a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (count == $past(count) + CNT_W'(1)));
   // R10: no tick, no movement
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));
   // R9: all-ones plus a tick returns to zero
   a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (&count)) |=> (count == '0));
endmodule

// File: rtl/usct_timebase.sv
module usct_timebase
   import usct_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int FIELD_W   = 8,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 7,
   parameter int CNT_OFS   = 16,
   parameter int CFG_OFS   = 20,
   parameter int WIN_BYTES = 96
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              usec_tick
);
   localparam int CFG_W = 2 * FIELD_W;

   if (CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("usct_timebase: count wider than the data port");
   end
   if (CFG_W > DATA_W) begin : g_bad_cfg_w
      $error("usct_timebase: scale register wider than the data port");
   end

   slot_e             slot;
   logic              cfg_we, rd_en, tick;
   logic [CFG_W-1:0]  cfg_q;
   logic [CNT_W-1:0]  count;
   logic [DATA_W-1:0] cnt_ext, cfg_ext, rd_mux;

   usct_decode #(
      .ADDR_W(ADDR_W), .CNT_OFS(CNT_OFS), .CFG_OFS(CFG_OFS), .WIN_BYTES(WIN_BYTES)
   ) u_dec (
      .addr(bus_addr),
      .slot(slot)
   );

   assign cfg_we = bus_sel && bus_wr && (slot == SLOT_SCALE);
   assign rd_en  = bus_sel && !bus_wr;

   always_ff @(posedge clk) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= bus_wdata[CFG_W-1:0];
   end

   if (DATA_W > CFG_W) begin : g_wdata_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CFG_W];
      assign cfg_ext = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
   end else begin : g_wdata_full
      assign cfg_ext = cfg_q;
   end

   usct_rate_accum #(.FIELD_W(FIELD_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (cfg_we),
      .num_m1(cfg_q[CFG_W-1:FIELD_W]),
      .den_m1(cfg_q[FIELD_W-1:0]),
      .tick  (tick)
   );

   usct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .count(count)
   );

   if (DATA_W > CNT_W) begin : g_cnt_pad
      assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, count};
   end else begin : g_cnt_full
      assign cnt_ext = count;
   end

   always_comb begin
      unique case (slot)
         SLOT_COUNT: rd_mux = cnt_ext;
         SLOT_SCALE: rd_mux = cfg_ext;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= rd_mux;
   end

   assign usec_tick = tick;

   // R4: at or above unity the count climbs one per cycle
   a_r4_unity_rate: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_q[CFG_W-1:FIELD_W] >= cfg_q[FIELD_W-1:0]) && !cfg_we)
      |=> (count == $past(count) + CNT_W'(1)));
   // R5: the count is frozen across a scale write
   a_r5_write_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> $stable(count));
   // R6: the scale register changes only through its own offset
   a_r6_cfg_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_q));
   // R8: read data holds between reads
   a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(bus_rdata));
   // R8: a count read shows the count of the strobe cycle
   a_r8_count_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (slot == SLOT_COUNT)) |=> (bus_rdata == $past(cnt_ext)));
endmodule

// File: tb/usct_timebase_test.sv
`timescale 1ns/1ps
module usct_timebase_test;
   localparam int NW = 10;
   localparam int MAXCYC = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata_w, rdata_n;
   logic        tick_w, tick_n;

   always #4 clk = ~clk;

   usct_timebase uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(rdata_w), .usec_tick(tick_w));

   usct_timebase #(.CNT_W(NW)) uut_narrow (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(rdata_n), .usec_tick(tick_n));

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model, written from R3/R4/R5
   longint edge_cnt = 0;
   longint seg_base = 0;
   longint seg_edge = 0;
   longint num = 1, den = 1;

   always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

   function automatic longint exp_count(longint e);
      longint k = e - seg_edge;
      if (k <= 0) return seg_base;
      if (num >= den) return seg_base + k;
      return seg_base + (num * k) / den;
   endfunction

   // scoreboard
   logic [31:0] q_wide[$];
   logic [31:0] q_narrow[$];
   string       q_tag[$];
   logic        rd_seen = 1'b0;
   logic [31:0] last_wide = '0;

   always @(posedge clk) rd_seen <= bus_sel && !bus_wr;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rd_seen && q_wide.size() > 0) begin
         logic [31:0] ew, en;
         string t;
         ew = q_wide.pop_front();
         en = q_narrow.pop_front();
         t  = q_tag.pop_front();
         check(t, rdata_w, ew);
         check({t, " narrow"}, rdata_n, en);
         last_wide = ew;
      end
   end

   task automatic do_read(logic [6:0] a, string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      if (a == 7'h10) begin
         logic [31:0] v;
         v = 32'(exp_count(edge_cnt));
         q_wide.push_back(v);
         q_narrow.push_back(v & ((32'd1 << NW) - 1));
      end else if (a == 7'h14) begin
         q_wide.push_back(32'(((num - 1) << 8) | (den - 1)));
         q_narrow.push_back(32'(((num - 1) << 8) | (den - 1)));
      end else begin
         q_wide.push_back('0);
         q_narrow.push_back('0);
      end
      q_tag.push_back(tag);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic do_write(logic [6:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      if (a == 7'h14) begin
         seg_base = exp_count(edge_cnt);
         seg_edge = edge_cnt + 1;
         num = longint'(d[15:8]) + 1;
         den = longint'(d[7:0]) + 1;
      end
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   // idle cycles with per-cycle tick comparison (R10)
   task automatic idle_ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
         check("R10 tick", {31'd0, tick_w},
               {31'd0, exp_count(edge_cnt + 1) != exp_count(edge_cnt)});
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (MAXCYC) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 rdata in reset", rdata_w, 32'd0);
      rst_n = 1'b1;
      do_read(7'h14, "R1 scale after reset");
      do_read(7'h10, "R1 count from zero");
      idle_ticks(5);                               // R4 at the reset ratio 1/1
      do_read(7'h10, "R4 unity after reset");

      do_write(7'h14, 32'hFFFF_045F);              // 5/96
      do_read(7'h14, "R2 field layout upper bits dropped");
      do_read(7'h10, "R5 count unchanged by scale write");
      idle_ticks(96);
      do_read(7'h10, "R3 5/96 one period");
      idle_ticks(37);
      do_read(7'h10, "R3 5/96 partial");

      do_write(7'h10, 32'h0000_0000);              // R6 ignored
      do_write(7'h3C, 32'h0000_0707);              // R6 ignored
      do_read(7'h14, "R6 scale kept");
      do_read(7'h10, "R6 count kept");

      do_write(7'h14, 32'h0000_000B);              // 1/12
      idle_ticks(50);
      do_read(7'h10, "R3 1/12");
      do_write(7'h14, 32'h0000_000C);              // 1/13
      idle_ticks(40);
      do_read(7'h10, "R3 1/13");
      do_write(7'h14, 32'h0000_0019);              // 1/26
      idle_ticks(80);
      do_read(7'h10, "R3 1/26");

      do_write(7'h14, 32'h0000_045F);
      idle_ticks(30);
      do_write(7'h14, 32'h0000_045F);              // R5 re-write clears phase
      do_read(7'h10, "R5 count frozen at rewrite");
      idle_ticks(20);
      do_read(7'h10, "R5 phase restarted");

      do_write(7'h14, 32'h0000_0505);              // 6/6
      idle_ticks(10);
      do_read(7'h10, "R4 equal ratio");
      do_write(7'h14, 32'h0000_0A03);              // 11/4
      idle_ticks(10);
      do_read(7'h10, "R4 above unity one per cycle");

      do_read(7'h00, "R7 zero 0x00");
      do_read(7'h0C, "R7 zero 0x0C");
      do_read(7'h12, "R7 zero unaligned");
      do_read(7'h5C, "R7 zero 0x5C");
      do_read(7'h7C, "R7 zero past window");

      do_read(7'h10, "R8 snapshot");
      repeat (6) begin
         @(negedge clk);
         check("R8 hold", rdata_w, last_wide);
      end

      do_write(7'h14, 32'h0000_0000);
      idle_ticks(1100);                            // narrow count wraps (R9)
      do_read(7'h10, "R9 wrap");
      idle_ticks(3);
      finish_run();
   end
endmodule